// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is an independent watchdog. Once started, a down-counter decrements once per prescaled tick. When it runs out, the block raises a one-cycle reset request and starts over from the reload value. Software refreshes the counter before it runs out. If software stops doing so, the chip is reset.

All control passes through 16-bit command words written to a single command address. Four cases are recognised:
- An unlock key opens the prescaler and reload registers for writing.
- A kick key refreshes the counter.
- A start key arms the timer.
- Any other word closes write access again.

An accepted prescaler or reload write holds a busy flag for a fixed number of cycles. This models the transfer into the counting domain. The new value only governs counting once that flag drops.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the timer is stopped and write access is closed. The prescaler code reads 0, the reload value reads 0xFFF, the status reads 0 and `wdog_rst_req` is low.
- R2: Address map on the 16-bit bus:
  - address 0 is the command word and reads 0.
  - address 1 holds the prescaler code in bits 2:0.
  - address 2 holds the reload value in bits 11:0.
  - address 3 is status: bit 0 is prescaler busy, bit 1 is reload busy.
  - Unused read bits are 0.
- R3: Writing 0x5555 to address 0 opens write access. Writing 0xAAAA or 0xCCCC leaves access unchanged. Any other command word closes it.
- R4: Prescaler or reload writes while access is closed are ignored. The readback is unchanged and no busy flag is set.
- R5: A reload write keeps only bits 11:0 of the data.
- R6: An accepted write sets its busy flag for exactly 4 clock cycles. A write to the same register while its flag is set is ignored. The counter keeps using the previous value until the flag clears.
- R7: Command 0xCCCC starts a stopped timer. It loads the counter with the active reload value R and clears the prescaler. The first reset request is high in the cycle that begins R*D clock edges after the write edge. D is 4 shifted left by the prescaler code, and code 7 gives 256.
- R8: Once running, no command stops the timer. A second 0xCCCC has no effect.
- R9: On expiry `wdog_rst_req` is high for exactly one cycle and the counter reloads, so requests repeat every R*D cycles.
- R10: Command 0xAAAA reloads the counter and clears the prescaler. If it falls on the same edge as an expiry, the kick wins and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counting |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| wdog_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A software kick and a counter expiry can land on the same clock edge. The bench counts edges from a known kick, then writes the kick key exactly on the edge where the count would reach zero. It judges the outcome by seeing no reset request in the following cycle and the next request one full period later. A second overlap, a reload write still busy while a kick arrives, is provoked by kicking one cycle after the write. It is judged by whether the next request follows the old or the new period.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam logic [15:0] KEY_UNLOCK = 16'h5555;
   localparam logic [15:0] KEY_KICK   = 16'hAAAA;
   localparam logic [15:0] KEY_START  = 16'hCCCC;

   typedef enum logic [1:0] {
      ADR_CMD  = 2'd0,
      ADR_PSC  = 2'd1,
      ADR_RLD  = 2'd2,
      ADR_STAT = 2'd3
   } wdk_addr_e;
endpackage

// File: rtl/wdk_keydec.sv
module wdk_keydec
   import wdk_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic             unlock_o,
   output logic             kick_o,
   output logic             start_o
);
   logic is_unlock, is_kick, is_start;
   logic unlock_q;

   assign is_unlock = (cmd_i == CMD_W'(KEY_UNLOCK));
   assign is_kick   = (cmd_i == CMD_W'(KEY_KICK));
   assign is_start  = (cmd_i == CMD_W'(KEY_START));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlock_q <= 1'b0;
      end else if (cmd_we_i) begin
         if (is_unlock)                unlock_q <= 1'b1;
         else if (!is_kick && !is_start) unlock_q <= 1'b0;
      end
   end

   assign unlock_o = unlock_q;
   assign kick_o   = cmd_we_i && is_kick;
   assign start_o  = cmd_we_i && is_start;

   assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && !is_unlock && !is_kick && !is_start) |=> !unlock_o);
   assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && is_unlock) |=> unlock_o);
endmodule

// File: rtl/wdk_cfg_reg.sv
module wdk_cfg_reg #(
   parameter int          W        = 12,
   parameter int          BUSY_CYC = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic         unlock_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] shadow_o,
   output logic [W-1:0] active_o,
   output logic         busy_o
);
   localparam int BC_W = $clog2(BUSY_CYC + 1);

   generate
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("wdk_cfg_reg: BUSY_CYC must be at least 1");
      end
   endgenerate

   logic [BC_W-1:0] bc_q;
   logic [W-1:0]    shadow_q, active_q;
   logic            accept;

   assign busy_o = (bc_q != '0);
   assign accept = wr_i && unlock_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc_q     <= '0;
         shadow_q <= RST_VAL;
         active_q <= RST_VAL;
      end else if (accept) begin
         bc_q     <= BC_W'(BUSY_CYC);
         shadow_q <= data_i;
      end else if (busy_o) begin
         bc_q <= bc_q - 1'b1;
         if (bc_q == BC_W'(1)) active_q <= shadow_q;
      end
   end

   assign shadow_o = shadow_q;
   assign active_o = active_q;

   assert_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o);
   assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(active_o) || !busy_o));
   assert_locked_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !unlock_i) |=> $stable(shadow_o));
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
   parameter int SEL_W        = 3,
   parameter int NUM_DIV      = 7,
   parameter int MIN_DIV_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int PRE_W = MIN_DIV_LOG2 + NUM_DIV - 1;

   generate
      if (NUM_DIV < 1 || NUM_DIV > (1 << SEL_W)) begin : g_bad_div
         $error("wdk_prescaler: NUM_DIV must fit the select code");
      end
      if (MIN_DIV_LOG2 < 1) begin : g_bad_min
         $error("wdk_prescaler: MIN_DIV_LOG2 must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] lim [NUM_DIV];
   logic [PRE_W-1:0] pre_q;
   logic [SEL_W-1:0] idx;

   for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_lim
      assign lim[gi] = PRE_W'((1 << (MIN_DIV_LOG2 + gi)) - 1);
   end

   always_comb begin
      idx = SEL_W'(NUM_DIV - 1);
      if (int'(sel_i) < NUM_DIV) idx = sel_i;
   end

   assign tick_o = run_i && (pre_q == lim[idx]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pre_q <= '0;
      else if (clr_i || !run_i)    pre_q <= '0;
      else if (tick_o)             pre_q <= '0;
      else                         pre_q <= pre_q + 1'b1;
   end

   assert_no_tick_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> !tick_o);
   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (pre_q == '0));
endmodule

// File: rtl/wdk_downcnt.sv
module wdk_downcnt #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             kick_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             running_o,
   output logic             load_o,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, exp_q;

   assign load_o = kick_i || (start_i && !run_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (start_i) run_q <= 1'b1;
         if (load_o) begin
            cnt_q <= reload_i;
         end else if (run_q && tick_i) begin
            if (cnt_q <= CNT_W'(1)) begin
               cnt_q <= reload_i;
               exp_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign running_o = run_q;
   assign expire_o  = exp_q;

   assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);
   assert_kick_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !expire_o);
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> !expire_o);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdk_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CNT_W        = 12,
   parameter int SEL_W        = 3,
   parameter int NUM_DIV      = 7,
   parameter int MIN_DIV_LOG2 = 2,
   parameter int BUSY_CYC     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdog_rst_req
);
   localparam logic [CNT_W-1:0] RLD_RST = '1;

   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("keyed_wdog: DATA_W must hold a 16-bit key");
      end
      if (CNT_W > DATA_W || SEL_W > DATA_W) begin : g_bad_fields
         $error("keyed_wdog: fields must fit the data width");
      end
   endgenerate

   logic             cmd_we, psc_we, rld_we;
   logic             unlock, kick, start;
   logic [SEL_W-1:0] psc_shadow, psc_active;
   logic [CNT_W-1:0] rld_shadow, rld_active;
   logic             psc_busy, rld_busy;
   logic             running, load, tick, expire;

   assign cmd_we = bus_we && (bus_addr == ADR_CMD);
   assign psc_we = bus_we && (bus_addr == ADR_PSC);
   assign rld_we = bus_we && (bus_addr == ADR_RLD);

   wdk_keydec #(.CMD_W(DATA_W)) u_keydec (
      .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .cmd_i(bus_wdata),
      .unlock_o(unlock), .kick_o(kick), .start_o(start)
   );

   wdk_cfg_reg #(.W(SEL_W), .BUSY_CYC(BUSY_CYC), .RST_VAL('0)) u_psc (
      .clk(clk), .rst_n(rst_n), .wr_i(psc_we), .unlock_i(unlock),
      .data_i(bus_wdata[SEL_W-1:0]), .shadow_o(psc_shadow),
      .active_o(psc_active), .busy_o(psc_busy)
   );

   wdk_cfg_reg #(.W(CNT_W), .BUSY_CYC(BUSY_CYC), .RST_VAL(RLD_RST)) u_rld (
      .clk(clk), .rst_n(rst_n), .wr_i(rld_we), .unlock_i(unlock),
      .data_i(bus_wdata[CNT_W-1:0]), .shadow_o(rld_shadow),
      .active_o(rld_active), .busy_o(rld_busy)
   );

   wdk_prescaler #(.SEL_W(SEL_W), .NUM_DIV(NUM_DIV), .MIN_DIV_LOG2(MIN_DIV_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(running), .clr_i(load),
      .sel_i(psc_active), .tick_o(tick)
   );

   wdk_downcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start_i(start), .kick_i(kick),
      .tick_i(tick), .reload_i(rld_active), .running_o(running),
      .load_o(load), .expire_o(expire)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_PSC:  bus_rdata[SEL_W-1:0] = psc_shadow;
         ADR_RLD:  bus_rdata[CNT_W-1:0] = rld_shadow;
         ADR_STAT: bus_rdata[1:0]       = {rld_busy, psc_busy};
         default:  bus_rdata = '0;
      endcase
   end

   assign wdog_rst_req = expire;

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |=> !wdog_rst_req);
   assert_cmd_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADR_CMD) |-> (bus_rdata == '0));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        wdog_rst_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   keyed_wdog u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_req(wdog_rst_req)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic expect_pulse(input int n, input string tag);
      step(n - 1);
      check({tag, " before expiry"}, 16'(wdog_rst_req), 16'h0);
      step(1);
      check({tag, " at expiry"}, 16'(wdog_rst_req), 16'h1);
      step(1);
      check({tag, " after expiry"}, 16'(wdog_rst_req), 16'h0);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      check("R1 rst_req", 16'(wdog_rst_req), 16'h0);
      rd(2'd0, d); check("R2 cmd reads 0", d, 16'h0);
      rd(2'd1, d); check("R1 psc reset", d, 16'h0);
      rd(2'd2, d); check("R1 reload reset", d, 16'h0FFF);
      rd(2'd3, d); check("R1 status reset", d, 16'h0);
   endtask

   task automatic t_locked;
      logic [15:0] d;
      wr(2'd1, 16'h0005);
      wr(2'd2, 16'h0010);
      rd(2'd1, d); check("R4 locked psc", d, 16'h0);
      rd(2'd2, d); check("R4 locked reload", d, 16'h0FFF);
      rd(2'd3, d); check("R4 no busy", d, 16'h0);
      step(6);
      check("R1 idle no request", 16'(wdog_rst_req), 16'h0);
   endtask

   task automatic t_busy;
      logic [15:0] d;
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'h0001);
      wr(2'd1, 16'h0002);
      rd(2'd1, d); check("R3 R6 psc accepted, busy write ignored", d, 16'h0001);
      step(2);
      rd(2'd3, d); check("R6 busy at 3", d, 16'h0001);
      step(1);
      rd(2'd3, d); check("R6 busy clear at 4", d, 16'h0);
   endtask

   task automatic t_relock;
      logic [15:0] d;
      wr(2'd0, 16'h1234);
      wr(2'd1, 16'h0003);
      rd(2'd1, d); check("R3 relock", d, 16'h0001);
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'h0000);
      step(4);
      wr(2'd2, 16'hF003);
      rd(2'd2, d); check("R5 reload masked", d, 16'h0003);
      rd(2'd3, d); check("R6 reload busy bit", d, 16'h0002);
      step(4);
   endtask

   task automatic t_run;
      wr(2'd0, 16'hCCCC);
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'hCCCC);
      step(9);
      check("R7 R8 before first expiry", 16'(wdog_rst_req), 16'h0);
      step(1);
      check("R7 first expiry at 12", 16'(wdog_rst_req), 16'h1);
      step(1);
      check("R9 one cycle", 16'(wdog_rst_req), 16'h0);
      step(10);
      check("R9 before second", 16'(wdog_rst_req), 16'h0);
      step(1);
      check("R9 second expiry at 24", 16'(wdog_rst_req), 16'h1);
      step(1);
   endtask

   task automatic t_kick;
      step(4);
      wr(2'd0, 16'hAAAA);
      step(6);
      check("R10 kick postpones", 16'(wdog_rst_req), 16'h0);
      step(5);
      check("R10 before new expiry", 16'(wdog_rst_req), 16'h0);
      step(1);
      check("R10 expiry after kick", 16'(wdog_rst_req), 16'h1);
      step(1);
      step(10);
      wr(2'd0, 16'hAAAA);
      check("R10 kick on expiry edge wins", 16'(wdog_rst_req), 16'h0);
      expect_pulse(12, "R10 period after collision");
   endtask

   task automatic t_apply;
      logic [15:0] d;
      wr(2'd0, 16'h5555);
      wr(2'd2, 16'h0005);
      wr(2'd0, 16'hAAAA);
      expect_pulse(12, "R6 old reload while busy");
      wr(2'd0, 16'hAAAA);
      expect_pulse(20, "R6 new reload after busy");
      wr(2'd1, 16'h0007);
      step(4);
      rd(2'd1, d); check("R7 psc code 7", d, 16'h0007);
      wr(2'd0, 16'hAAAA);
      expect_pulse(1280, "R7 code 7 divides by 256");
   endtask

   initial begin
      @(negedge clk);
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset;
      t_locked;
      t_busy;
      t_relock;
      t_run;
      t_kick;
      t_apply;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule